// File: doc/BRIEF.md
# Byte-to-word DMA write packer

This block sits between a serial receive core and a simple memory write bus. Software programs a byte start address, a byte count and a strobe mode, then raises the DMA enable. Each byte the serial core presents is taken into the next free lane of a 32-bit word, with the earliest byte in the lowest lane. When a word is full, or when the byte budget runs out, the block raises a single write request. The request carries the running address, the packed data and the byte strobes, and it is held until the bus acknowledges it.

Each acknowledged write moves the running address on by four, and that address can be read as status. A budget that is not a multiple of four ends in a partial word. The unused upper bytes of that word are zero. Its strobes either mark only the filled lanes or, in the full-word mode, are all set. After the last write, or at once for a zero budget, a done interrupt is latched and held until software clears it. A software reset drops any request and the interrupt, and holds the block idle.

Top module: `dma_wpack`

## Requirements
- R1: After reset, wr_req, done_irq and byte_rdy are 0 and cur_addr is 0.
- R2: A rising dma_en while the block is idle and sw_rst is 0 loads start_addr into cur_addr in the next cycle. byte_rdy then goes to 1 when xfer_len is non-zero.
- R3: Four accepted bytes b0..b3 produce one write with wr_data = {b3,b2,b1,b0}, so the first byte lands in bits 7:0, and wr_be = 4'b1111.
- R4: While wr_req is 1 and wr_ack is 0, wr_req, wr_addr, wr_data and wr_be keep their values into the next cycle. byte_rdy is 0 while wr_req is 1.
- R5: The first write goes to start_addr. After each acknowledged write, cur_addr and the address of the next write are 4 higher.
- R6: The number of bytes accepted never exceeds xfer_len. Once xfer_len bytes have been taken, byte_rdy stays 0 and further byte_vld pulses produce no write.
- R7: With wr_no_be = 0, a final word that holds n < 4 bytes has wr_be bit i set exactly for i < n, and its upper bytes are 0.
- R8: With wr_no_be = 1, every write, including a partial final word, has wr_be = 4'b1111, and the unused upper bytes are 0.
- R9: done_irq goes to 1 in the cycle after the final write is acknowledged. It stays 1 until done_clr is applied. If the final acknowledge and done_clr fall in the same cycle, done_irq still becomes 1.
- R10: A start with xfer_len = 0 issues no write and sets done_irq in the next cycle.
- R11: sw_rst = 1 clears wr_req, byte_rdy and done_irq in the next cycle. While sw_rst stays 1, a rising dma_en starts nothing.
- R12: While dma_en is 0 during a transfer, byte_rdy is 0 and no byte is taken. When dma_en returns to 1, packing resumes in the same word without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Software reset level, returns to idle |
| dma_en | input | 1 | DMA enable; a rise while idle starts a transfer |
| start_addr | input | 32 | Byte address of the first write |
| xfer_len | input | 18 | Transfer length in bytes |
| wr_no_be | input | 1 | 1: all strobes set on every write; 0: strobes mark filled lanes |
| byte_vld | input | 1 | Received byte present |
| byte_dat | input | 8 | Received byte |
| byte_rdy | output | 1 | Byte taken in a cycle where byte_vld is also 1 |
| wr_req | output | 1 | Word write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Packed write data |
| wr_be | output | 4 | Byte strobes |
| wr_ack | input | 1 | Bus accepts the request in this cycle |
| cur_addr | output | 32 | Running address status |
| done_irq | output | 1 | Transfer-complete interrupt status |
| done_clr | input | 1 | Clears done_irq |

## Verification
The acknowledge of a transfer's final write can arrive in the same cycle as a software clear of the interrupt. In that case the new completion must survive. The bench provokes this by holding back the acknowledge of a one-byte transfer, then raising wr_ack and done_clr in the same cycle. It judges the outcome by requiring done_irq to read 1 in the following cycle and to fall only after a separate clear pulse.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/dwp_packer.sv
module dwp_packer #(
    parameter int BPW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     take,
    input  logic                     last,
    input  logic [7:0]               dat,
    output logic                     emit,
    output logic [8*BPW-1:0]         word,
    output logic [$clog2(BPW+1)-1:0] fill
);
    localparam int DW = 8 * BPW;
    localparam int CW = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int NW = $clog2(BPW + 1);

    typedef struct packed {
        logic [CW-1:0] lane;
        logic [DW-1:0] acc;
    } pk_state_t;

    pk_state_t s_q, s_d;
    logic [DW-1:0] merged;

    always_comb begin
        merged = s_q.acc;
        for (int i = 0; i < BPW; i++) begin
            if (s_q.lane == CW'(i)) merged[i*8 +: 8] = dat;
        end
        emit = take && ((s_q.lane == CW'(BPW - 1)) || last);
        word = merged;
        fill = NW'(s_q.lane) + NW'(1);

        s_d = s_q;
        if (clr || emit) begin
            s_d.lane = '0;
            s_d.acc  = '0;
        end else if (take) begin
            s_d.lane = s_q.lane + CW'(1);
            s_d.acc  = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a word leaves and the next byte starts again in lane 0
    a_r3_lane_restart: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> (s_q.lane == '0));

    // R7: an emitted word never claims more lanes than a word has
    a_r7_fill_range: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (fill >= NW'(1) && fill <= NW'(BPW)));
endmodule

// File: rtl/dwp_seq.sv
module dwp_seq #(
    parameter int AW  = 32,
    parameter int LW  = 18,
    parameter int BPW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sw_rst,
    input  logic                     dma_en,
    input  logic [AW-1:0]            start_addr,
    input  logic [LW-1:0]            xfer_len,
    input  logic                     no_be,
    input  logic                     byte_vld,
    input  logic                     emit,
    input  logic [8*BPW-1:0]         word,
    input  logic [$clog2(BPW+1)-1:0] fill,
    input  logic                     wr_ack,
    output logic                     byte_rdy,
    output logic                     take,
    output logic                     last,
    output logic                     wr_req,
    output logic [AW-1:0]            wr_addr,
    output logic [8*BPW-1:0]         wr_data,
    output logic [BPW-1:0]           wr_be,
    output logic                     finish
);
    import dwp_pkg::*;

    localparam int DW = 8 * BPW;
    localparam int NW = $clog2(BPW + 1);

    typedef struct packed {
        seq_mode_e     mode;
        logic          en_prev;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic          req;
        logic [DW-1:0] data;
        logic [BPW-1:0] be;
    } sq_state_t;

    sq_state_t s_q, s_d;
    logic start_now, accept_wr;
    logic [BPW-1:0] lane_mask;

    always_comb begin
        start_now = dma_en && !s_q.en_prev && (s_q.mode == SEQ_IDLE) && !sw_rst;
        byte_rdy  = (s_q.mode == SEQ_RUN) && dma_en && !s_q.req &&
                    (s_q.remain != '0) && !sw_rst;
        take      = byte_vld && byte_rdy;
        last      = (s_q.remain == LW'(1));
        accept_wr = s_q.req && wr_ack && !sw_rst;
        finish    = (accept_wr && (s_q.remain == '0)) ||
                    (start_now && (xfer_len == '0));

        for (int i = 0; i < BPW; i++) lane_mask[i] = (NW'(i) < fill);

        s_d = s_q;
        s_d.en_prev = dma_en;
        if (sw_rst) begin
            s_d.mode = SEQ_IDLE;
            s_d.req  = 1'b0;
        end else if (start_now) begin
            s_d.addr   = start_addr;
            s_d.remain = xfer_len;
            s_d.mode   = (xfer_len != '0) ? SEQ_RUN : SEQ_IDLE;
        end else begin
            if (take) s_d.remain = s_q.remain - LW'(1);
            if (emit) begin
                s_d.req  = 1'b1;
                s_d.data = word;
                s_d.be   = no_be ? '1 : lane_mask;
            end
            if (accept_wr) begin
                s_d.req  = 1'b0;
                s_d.addr = s_q.addr + AW'(BPW);
                if (s_q.remain == '0) s_d.mode = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_req  = s_q.req;
    assign wr_addr = s_q.addr;
    assign wr_data = s_q.data;
    assign wr_be   = s_q.be;

    // R4: an unanswered request keeps its payload
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !sw_rst) |=>
        (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    // R4: no byte is taken while a word waits on the bus
    a_r4_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !take);

    // R5: an acknowledged write steps the address by one word
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && !sw_rst) |=> (wr_addr == $past(wr_addr) + AW'(BPW)));

    // R6: the byte budget only shrinks between starts
    a_r6_budget: assert property (@(posedge clk) disable iff (!rst_n)
        !start_now |=> (s_q.remain <= $past(s_q.remain)));
endmodule

// File: rtl/dwp_done.sv
module dwp_done (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic irq_q, irq_d;

    always_comb begin
        irq_d = irq_q;
        if (sw_rst)   irq_d = 1'b0;
        else if (set) irq_d = 1'b1;
        else if (clr) irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R9: completion wins over a clear in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !sw_rst) |=> irq);

    // R9: status holds until cleared
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr && !sw_rst) |=> irq);

    // R11: software reset drops the status
    a_r11_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !irq);
endmodule

// File: rtl/dma_wpack.sv
module dma_wpack #(
    parameter int AW  = 32,
    parameter int LW  = 18,
    parameter int BPW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst,
    input  logic               dma_en,
    input  logic [AW-1:0]      start_addr,
    input  logic [LW-1:0]      xfer_len,
    input  logic               wr_no_be,
    input  logic               byte_vld,
    input  logic [7:0]         byte_dat,
    output logic               byte_rdy,
    output logic               wr_req,
    output logic [AW-1:0]      wr_addr,
    output logic [8*BPW-1:0]   wr_data,
    output logic [BPW-1:0]     wr_be,
    input  logic               wr_ack,
    output logic [AW-1:0]      cur_addr,
    output logic               done_irq,
    input  logic               done_clr
);
    localparam int DW = 8 * BPW;
    localparam int NW = $clog2(BPW + 1);

    logic          take, last, emit, finish;
    logic [DW-1:0] word;
    logic [NW-1:0] fill;

    dwp_packer #(.BPW(BPW)) u_pack (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sw_rst),
        .take (take),
        .last (last),
        .dat  (byte_dat),
        .emit (emit),
        .word (word),
        .fill (fill)
    );

    dwp_seq #(.AW(AW), .LW(LW), .BPW(BPW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .dma_en    (dma_en),
        .start_addr(start_addr),
        .xfer_len  (xfer_len),
        .no_be     (wr_no_be),
        .byte_vld  (byte_vld),
        .emit      (emit),
        .word      (word),
        .fill      (fill),
        .wr_ack    (wr_ack),
        .byte_rdy  (byte_rdy),
        .take      (take),
        .last      (last),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .finish    (finish)
    );

    dwp_done u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_rst(sw_rst),
        .set   (finish),
        .clr   (done_clr),
        .irq   (done_irq)
    );

    assign cur_addr = wr_addr;
endmodule

// File: tb/sim_dma_wpack.sv
`timescale 1ns/1ps
module sim_dma_wpack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0, dma_en = 1'b0, wr_no_be = 1'b0;
    logic [31:0] start_addr = '0;
    logic [17:0] xfer_len = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic        byte_rdy, wr_req, wr_ack = 1'b1, done_irq, done_clr = 1'b0;
    logic [31:0] wr_addr, wr_data, cur_addr;
    logic [3:0]  wr_be;

    int nchk = 0, nfail = 0, nlog = 0;
    logic [31:0] la [0:15];
    logic [31:0] ld [0:15];
    logic [3:0]  lb [0:15];

    always #2.5 clk = ~clk;

    dma_wpack u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .dma_en(dma_en),
        .start_addr(start_addr), .xfer_len(xfer_len), .wr_no_be(wr_no_be),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_rdy(byte_rdy),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ack(wr_ack), .cur_addr(cur_addr), .done_irq(done_irq),
        .done_clr(done_clr)
    );

    always @(negedge clk) begin
        #2;
        if (wr_req && wr_ack && nlog < 16) begin
            la[nlog] = wr_addr; ld[nlog] = wr_data; lb[nlog] = wr_be;
            nlog++;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [31:0] a, input logic [17:0] l, input logic nb);
        dma_en = 1'b0; tick();
        start_addr = a; xfer_len = l; wr_no_be = nb; dma_en = 1'b1; nlog = 0;
        tick();
    endtask

    task automatic push(input logic [7:0] b);
        byte_vld = 1'b1; byte_dat = b;
        while (!byte_rdy) tick();
        tick();
        byte_vld = 1'b0;
    endtask

    task automatic clear_done();
        done_clr = 1'b1; tick(); done_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 wr_req", {31'd0, wr_req}, 32'd0);
        chk("R1 done_irq", {31'd0, done_irq}, 32'd0);
        chk("R1 byte_rdy", {31'd0, byte_rdy}, 32'd0);
        chk("R1 cur_addr", cur_addr, 32'd0);
    endtask

    task automatic t_full_words();
        wr_ack = 1'b1;
        start(32'h1000, 18'd8, 1'b0);
        chk("R2 cur_addr load", cur_addr, 32'h1000);
        chk("R2 byte_rdy", {31'd0, byte_rdy}, 32'd1);
        for (int i = 0; i < 8; i++) push(8'h11 + 8'(i));
        tick(3);
        chk("R3 count", nlog, 2);
        chk("R5 addr0", la[0], 32'h1000);
        chk("R3 data0", ld[0], 32'h14131211);
        chk("R3 be0", {28'd0, lb[0]}, 32'hF);
        chk("R5 addr1", la[1], 32'h1004);
        chk("R3 data1", ld[1], 32'h18171615);
        chk("R5 cur_addr end", cur_addr, 32'h1008);
        chk("R9 done set", {31'd0, done_irq}, 32'd1);
        chk("R6 rdy after budget", {31'd0, byte_rdy}, 32'd0);
        byte_vld = 1'b1; byte_dat = 8'hAA; tick(3); byte_vld = 1'b0;
        chk("R6 no extra write", nlog, 2);
        tick(2);
        chk("R9 hold", {31'd0, done_irq}, 32'd1);
        clear_done();
        chk("R9 cleared", {31'd0, done_irq}, 32'd0);
    endtask

    task automatic t_partial_be();
        start(32'h2000, 18'd6, 1'b0);
        for (int i = 0; i < 6; i++) push(8'h21 + 8'(i));
        tick(3);
        chk("R7 count", nlog, 2);
        chk("R7 data0", ld[0], 32'h24232221);
        chk("R7 addr1", la[1], 32'h2004);
        chk("R7 data1", ld[1], 32'h00002625);
        chk("R7 be1", {28'd0, lb[1]}, 32'h3);
        clear_done();
    endtask

    task automatic t_partial_nobe();
        start(32'h3000, 18'd5, 1'b1);
        for (int i = 0; i < 5; i++) push(8'h31 + 8'(i));
        tick(3);
        chk("R8 count", nlog, 2);
        chk("R8 be0", {28'd0, lb[0]}, 32'hF);
        chk("R8 data1", ld[1], 32'h00000035);
        chk("R8 be1", {28'd0, lb[1]}, 32'hF);
        clear_done();
    endtask

    task automatic t_stall();
        logic [31:0] a0, d0;
        logic [3:0]  b0;
        wr_ack = 1'b0;
        start(32'h4000, 18'd4, 1'b0);
        for (int i = 0; i < 4; i++) push(8'hC0 + 8'(i));
        chk("R4 req up", {31'd0, wr_req}, 32'd1);
        a0 = wr_addr; d0 = wr_data; b0 = wr_be;
        tick(3);
        chk("R4 req held", {31'd0, wr_req}, 32'd1);
        chk("R4 addr held", wr_addr, a0);
        chk("R4 data held", wr_data, d0);
        chk("R4 be held", {28'd0, wr_be}, {28'd0, b0});
        chk("R4 data value", wr_data, 32'hC3C2C1C0);
        chk("R4 rdy low", {31'd0, byte_rdy}, 32'd0);
        wr_ack = 1'b1; tick();
        chk("R5 req drop", {31'd0, wr_req}, 32'd0);
        chk("R5 cur_addr step", cur_addr, 32'h4004);
        clear_done();
    endtask

    task automatic t_set_clr_clash();
        wr_ack = 1'b0;
        start(32'h5000, 18'd1, 1'b0);
        push(8'h77);
        chk("R9 clash req", {31'd0, wr_req}, 32'd1);
        wr_ack = 1'b1; done_clr = 1'b1; tick();
        done_clr = 1'b0;
        chk("R9 set wins", {31'd0, done_irq}, 32'd1);
        chk("R7 single byte be", {28'd0, lb[0]}, 32'h1);
        chk("R7 single byte data", ld[0], 32'h00000077);
        tick();
        chk("R9 stays", {31'd0, done_irq}, 32'd1);
        clear_done();
        chk("R9 clear after", {31'd0, done_irq}, 32'd0);
    endtask

    task automatic t_pause();
        wr_ack = 1'b1;
        start(32'h6000, 18'd4, 1'b0);
        push(8'h01); push(8'h02);
        dma_en = 1'b0; tick();
        chk("R12 rdy low", {31'd0, byte_rdy}, 32'd0);
        byte_vld = 1'b1; byte_dat = 8'hEE; tick(3); byte_vld = 1'b0;
        dma_en = 1'b1; tick();
        chk("R12 resume addr", cur_addr, 32'h6000);
        push(8'h03); push(8'h04);
        tick(3);
        chk("R12 count", nlog, 1);
        chk("R12 data", ld[0], 32'h04030201);
        clear_done();
    endtask

    task automatic t_zero_len();
        start(32'h7000, 18'd0, 1'b0);
        chk("R10 done", {31'd0, done_irq}, 32'd1);
        chk("R10 rdy", {31'd0, byte_rdy}, 32'd0);
        tick(3);
        chk("R10 no write", nlog, 0);
    endtask

    task automatic t_sw_rst();
        wr_ack = 1'b0;
        start(32'h8000, 18'd8, 1'b0);
        for (int i = 0; i < 4; i++) push(8'h51 + 8'(i));
        chk("R11 pre req", {31'd0, wr_req}, 32'd1);
        chk("R11 pre done", {31'd0, done_irq}, 32'd1);
        sw_rst = 1'b1; tick();
        chk("R11 req cleared", {31'd0, wr_req}, 32'd0);
        chk("R11 rdy cleared", {31'd0, byte_rdy}, 32'd0);
        chk("R11 done cleared", {31'd0, done_irq}, 32'd0);
        dma_en = 1'b0; tick(); dma_en = 1'b1; tick();
        chk("R11 no start in reset", {31'd0, byte_rdy}, 32'd0);
        sw_rst = 1'b0; wr_ack = 1'b1; tick(2);
        chk("R11 idle after", {31'd0, byte_rdy}, 32'd0);
        chk("R11 no write", nlog, 0);
    endtask

    initial begin
        tick(2);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_full_words();
        t_partial_be();
        t_partial_nobe();
        t_stall();
        t_set_clr_clash();
        t_pause();
        t_zero_len();
        t_sw_rst();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=done", nchk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule